// File: doc/BRIEF.md
# Cache Line Coherency State Controller

This block keeps the four-state coherency tag (Modified, Exclusive, Shared, Invalid) for every line of a small data cache. It decides, for each local read or write, whether the access can complete inside the cache or needs a bus transaction. It also applies the state change once that transaction is acknowledged. Other masters' bus traffic arrives on a snoop port as a line index and a read/write flag. A snooped write drops the local copy. A snooped read forces a dirty line to be written back and demotes exclusive ownership to shared.

Two configuration inputs select the operating mode. One switches off line fills. The other switches off write-through traffic and snoop reaction as well, and also blocks fills. Two commands act on the whole cache. The first discards every line at once. The second first walks the lines in ascending index, strobing a writeback for each dirty line, and then discards them all. Data storage, tag comparison and bus arbitration belong to the surrounding cache. This block sees line indices only and reports the state of the line addressed by the local port.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. `lcl_state` shows the state of line `lcl_idx` with the encoding Invalid=00, Shared=01, Exclusive=10, Modified=11. After reset `lcl_ready` is 1, and `bus_req` and `wb_valid` are 0.
- R2: An accepted local write to a Modified line raises no bus request and leaves the line Modified. An accepted local write to an Exclusive line raises no bus request, and the line reads Modified from the next cycle.
- R3: With write-through enabled, an accepted local write to a Shared or Invalid line raises `bus_req` from the next cycle with `bus_op`=10 and `bus_idx` equal to the line. The request is held until the cycle in which `bus_ack` is sampled high. After that edge a Shared line is Exclusive and an Invalid line stays Invalid.
- R4: An accepted local read of an Invalid line raises `bus_req` from the next cycle with `bus_op`=01, held until `bus_ack`. With fills enabled, the line becomes Shared if `bus_shared` is high in the acknowledge cycle, and Exclusive otherwise. A read of a valid line causes no bus request and no state change. `bus_op` is 00 whenever no request is raised.
- R5: With `cfg_fill_off`=1 and `cfg_wthru_off`=0, a read miss still performs the bus read, but the line stays Invalid after the acknowledge.
- R6: With `cfg_wthru_off`=1, whatever `cfg_fill_off` is: a write to a Shared or Invalid line raises no bus request and changes no state. Snoops change no state and raise no writeback.
- R7: A snooped write to a line that is not Invalid leaves it Invalid after the edge.
- R8: A snooped read of a Modified line raises `wb_valid` with `wb_idx` equal to the line in that same cycle, and the line becomes Shared. A snooped read of an Exclusive line makes it Shared with no writeback.
- R9: `cmd_inv_all` taken while `ctl_idle` is high makes every line Invalid after the edge and raises no writeback.
- R10: `cmd_flush_all` taken while idle starts a walk on the next cycle. The walk spends one cycle per line in ascending index and raises `wb_valid`/`wb_idx` in the cycle of each Modified line. After the last line every line is Invalid. `lcl_ready` and `ctl_idle` stay low during the walk.
- R11: If a snooped-read writeback falls in a walk cycle, the snoop's writeback takes `wb_valid`/`wb_idx`, and the walk repeats the same line in the next cycle.
- R12: `lcl_ready` is low while the block is not idle, while a command input is high, or while a snoop targets `lcl_idx`. A Shared line that a snooped write invalidates while its write-through is pending stays Invalid after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fill_off | input | 1 | Disable line fills |
| cfg_wthru_off | input | 1 | Disable write-through, snoop reaction and fills |
| lcl_valid | input | 1 | Local access present |
| lcl_write | input | 1 | Local access is a write |
| lcl_idx | input | IDX_W | Line addressed by the local port |
| lcl_ready | output | 1 | Local access accepted this cycle |
| lcl_state | output | 2 | State of line `lcl_idx` |
| snp_valid | input | 1 | Snooped bus transaction hits a held tag |
| snp_write | input | 1 | Snooped transaction is a write |
| snp_idx | input | IDX_W | Line hit by the snoop |
| bus_shared | input | 1 | Another cache holds the block being filled |
| bus_req | output | 1 | Bus transaction requested |
| bus_op | output | 2 | 01 read, 10 write, 00 none |
| bus_idx | output | IDX_W | Line of the requested transaction |
| bus_ack | input | 1 | Requested transaction completes this cycle |
| cmd_inv_all | input | 1 | Discard all lines |
| cmd_flush_all | input | 1 | Write back dirty lines, then discard all |
| wb_valid | output | 1 | Writeback of line `wb_idx` required this cycle |
| wb_idx | output | IDX_W | Line to write back |
| ctl_idle | output | 1 | No bus wait and no walk in progress |

## Verification
The hardest situation to reach is a snooped read of a dirty line that lands in the middle of a flush walk. The bench sets it up by making three lines dirty through fills and writes before starting the walk. It then injects the snoop in the exact cycle the walk reaches another dirty line, and checks that the walk holds for a cycle and still writes that line back. A second hard case is a snooped write that hits a Shared line whose write-through is still waiting for acknowledge. The bench holds `bus_ack` low for one cycle to open that window.

// File: rtl/coh_pkg.sv
// Shared types of the coherency state controller.
// Assumes: line state encoding is visible at the top ports, so it is fixed.
package coh_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_EXC = 2'b10,
        LS_MOD = 2'b11
    } line_st_t;

    typedef enum logic [1:0] {
        BOP_NONE = 2'b00,
        BOP_RD   = 2'b01,
        BOP_WR   = 2'b10
    } bus_op_t;

    typedef enum logic [2:0] {
        LU_NONE,
        LU_TO_MOD,
        LU_FILL_SHR,
        LU_FILL_EXC,
        LU_UPGRADE,
        LU_CLEAN,
        LU_INVAL
    } line_upd_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT,
        PH_WALK
    } ctl_phase_t;

endpackage

// File: rtl/coh_line_cell.sv
// One cache line's coherency state register.
// Applies the sequencer's update first, then the snoop on top of that result.
// Assumes: the sequencer never issues a local write update to the line a snoop targets.
module coh_line_cell
    import coh_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_upd_t upd,
    input  logic      snp_sel,
    input  logic      snp_write,
    input  logic      snp_en,
    output line_st_t  st_q
);

    line_st_t mid_st;
    line_st_t nxt_st;

    // Purpose: state after the local, acknowledge or walk update.
    always_comb begin
        mid_st = st_q;
        case (upd)
            LU_TO_MOD:   mid_st = LS_MOD;
            LU_FILL_SHR: mid_st = LS_SHR;
            LU_FILL_EXC: mid_st = LS_EXC;
            LU_UPGRADE:  if (st_q == LS_SHR) mid_st = LS_EXC;
            LU_CLEAN:    if (st_q == LS_MOD) mid_st = LS_EXC;
            LU_INVAL:    mid_st = LS_INV;
            default:     mid_st = st_q;
        endcase
    end

    // Purpose: snoop reaction applied to the updated state.
    always_comb begin
        nxt_st = mid_st;
        if (snp_sel && snp_en && (mid_st != LS_INV)) begin
            if (snp_write)
                nxt_st = LS_INV;
            else
                nxt_st = LS_SHR;
        end
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= LS_INV;
        else
            st_q <= nxt_st;
    end

endmodule

// File: rtl/coh_seq.sv
// Control sequencer: accepts local accesses and commands, waits for bus
// acknowledges, and walks the lines for the write-back-and-discard command.
// Assumes: one bus transaction outstanding at a time; LINES is a power of two.
module coh_seq
    import coh_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lcl_valid,
    input  logic             lcl_write,
    input  logic [IDX_W-1:0] lcl_idx,
    input  line_st_t         lcl_cur,
    input  logic             snp_conflict,
    input  logic             cmd_inv_all,
    input  logic             cmd_flush_all,
    input  logic             bus_ack,
    input  logic             bus_shared,
    input  logic             fill_en,
    input  logic             wthru_en,
    input  line_st_t         walk_cur,
    input  logic             snp_wb_take,
    output logic             idle,
    output logic             lcl_ready,
    output logic             bus_req,
    output bus_op_t          bus_op,
    output logic [IDX_W-1:0] bus_idx,
    output logic [IDX_W-1:0] upd_idx,
    output line_upd_t        upd_kind,
    output logic             all_inv,
    output logic             walk_wb,
    output logic [IDX_W-1:0] walk_ptr
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    ctl_phase_t       phase_q, phase_n;
    bus_op_t          pend_op_q, pend_op_n;
    logic [IDX_W-1:0] pend_idx_q, pend_idx_n;
    logic [IDX_W-1:0] ptr_q, ptr_n;
    logic             accept;

    assign idle      = (phase_q == PH_IDLE);
    assign lcl_ready = idle && !cmd_inv_all && !cmd_flush_all && !snp_conflict;
    assign accept    = lcl_valid && lcl_ready;
    assign bus_req   = (phase_q == PH_WAIT);
    assign bus_op    = bus_req ? pend_op_q : BOP_NONE;
    assign bus_idx   = pend_idx_q;
    assign walk_ptr  = ptr_q;

    // Purpose: next phase and the line update for this cycle.
    always_comb begin
        phase_n    = phase_q;
        pend_op_n  = pend_op_q;
        pend_idx_n = pend_idx_q;
        ptr_n      = ptr_q;
        upd_idx    = lcl_idx;
        upd_kind   = LU_NONE;
        all_inv    = 1'b0;
        walk_wb    = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (cmd_inv_all) begin
                    all_inv = 1'b1;
                end else if (cmd_flush_all) begin
                    phase_n = PH_WALK;
                    ptr_n   = '0;
                end else if (accept) begin
                    if (lcl_write) begin
                        if (lcl_cur == LS_EXC) begin
                            upd_kind = LU_TO_MOD;
                        end else if ((lcl_cur != LS_MOD) && wthru_en) begin
                            phase_n    = PH_WAIT;
                            pend_op_n  = BOP_WR;
                            pend_idx_n = lcl_idx;
                        end
                    end else if (lcl_cur == LS_INV) begin
                        phase_n    = PH_WAIT;
                        pend_op_n  = BOP_RD;
                        pend_idx_n = lcl_idx;
                    end
                end
            end
            PH_WAIT: begin
                if (bus_ack) begin
                    upd_idx = pend_idx_q;
                    phase_n = PH_IDLE;
                    if (pend_op_q == BOP_RD) begin
                        if (fill_en)
                            upd_kind = bus_shared ? LU_FILL_SHR : LU_FILL_EXC;
                    end else begin
                        upd_kind = LU_UPGRADE;
                    end
                end
            end
            PH_WALK: begin
                if (!snp_wb_take) begin
                    upd_idx = ptr_q;
                    if (walk_cur == LS_MOD) begin
                        walk_wb  = 1'b1;
                        upd_kind = LU_CLEAN;
                    end
                    if (ptr_q == LAST_IDX) begin
                        all_inv = 1'b1;
                        phase_n = PH_IDLE;
                    end else begin
                        ptr_n = ptr_q + 1'b1;
                    end
                end
            end
            default: phase_n = PH_IDLE;
        endcase
    end

    // Purpose: sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            pend_op_q  <= BOP_NONE;
            pend_idx_q <= '0;
            ptr_q      <= '0;
        end else begin
            phase_q    <= phase_n;
            pend_op_q  <= pend_op_n;
            pend_idx_q <= pend_idx_n;
            ptr_q      <= ptr_n;
        end
    end

endmodule

// File: rtl/coh_line_ctrl.sv
// Top: coherency state for LINES cache lines, local and snoop ports,
// operating modes and the two whole-cache commands.
// Assumes: snoop tag comparison is done outside; snp_valid means a held tag hit.
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_fill_off,
    input  logic             cfg_wthru_off,
    input  logic             lcl_valid,
    input  logic             lcl_write,
    input  logic [IDX_W-1:0] lcl_idx,
    output logic             lcl_ready,
    output logic [1:0]       lcl_state,
    input  logic             snp_valid,
    input  logic             snp_write,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic             bus_shared,
    output logic             bus_req,
    output logic [1:0]       bus_op,
    output logic [IDX_W-1:0] bus_idx,
    input  logic             bus_ack,
    input  logic             cmd_inv_all,
    input  logic             cmd_flush_all,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_idx,
    output logic             ctl_idle
);

    line_st_t         st [LINES];
    logic             fill_en, wthru_en, snoop_en;
    logic             snp_conflict, snp_wb_take;
    logic [IDX_W-1:0] upd_idx, walk_ptr;
    line_upd_t        upd_kind;
    logic             all_inv, walk_wb;
    bus_op_t          seq_op;

    // Mode decode: write-through off freezes everything; fill off only blocks fills.
    assign wthru_en = !cfg_wthru_off;
    assign snoop_en = !cfg_wthru_off;
    assign fill_en  = !cfg_fill_off && !cfg_wthru_off;

    assign snp_conflict = snp_valid && (snp_idx == lcl_idx);
    assign snp_wb_take  = snp_valid && !snp_write && snoop_en && (st[snp_idx] == LS_MOD);
    assign lcl_state    = st[lcl_idx];
    assign wb_valid     = snp_wb_take || walk_wb;
    assign wb_idx       = snp_wb_take ? snp_idx : walk_ptr;
    assign bus_op       = seq_op;

    coh_seq #(.LINES(LINES)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .lcl_valid     (lcl_valid),
        .lcl_write     (lcl_write),
        .lcl_idx       (lcl_idx),
        .lcl_cur       (st[lcl_idx]),
        .snp_conflict  (snp_conflict),
        .cmd_inv_all   (cmd_inv_all),
        .cmd_flush_all (cmd_flush_all),
        .bus_ack       (bus_ack),
        .bus_shared    (bus_shared),
        .fill_en       (fill_en),
        .wthru_en      (wthru_en),
        .walk_cur      (st[walk_ptr]),
        .snp_wb_take   (snp_wb_take),
        .idle          (ctl_idle),
        .lcl_ready     (lcl_ready),
        .bus_req       (bus_req),
        .bus_op        (seq_op),
        .bus_idx       (bus_idx),
        .upd_idx       (upd_idx),
        .upd_kind      (upd_kind),
        .all_inv       (all_inv),
        .walk_wb       (walk_wb),
        .walk_ptr      (walk_ptr)
    );

    // One state cell per line; the update is steered by index.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_upd_t cell_upd;
        assign cell_upd = all_inv ? LU_INVAL
                        : ((upd_idx == IDX_W'(i)) ? upd_kind : LU_NONE);
        coh_line_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd       (cell_upd),
            .snp_sel   (snp_valid && (snp_idx == IDX_W'(i))),
            .snp_write (snp_write),
            .snp_en    (snoop_en),
            .st_q      (st[i])
        );
    end

endmodule

// File: rtl/coh_line_ctrl_chk.sv
// Checker for the coherency state controller, bound to the top module.
// Assumes: it observes top-level ports only.
module coh_line_ctrl_chk #(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wthru_off,
    input logic             lcl_valid,
    input logic             lcl_write,
    input logic [IDX_W-1:0] lcl_idx,
    input logic             lcl_ready,
    input logic [1:0]       lcl_state,
    input logic             snp_valid,
    input logic [IDX_W-1:0] snp_idx,
    input logic             bus_req,
    input logic [1:0]       bus_op,
    input logic [IDX_W-1:0] bus_idx,
    input logic             bus_ack,
    input logic             cmd_inv_all,
    input logic             wb_valid,
    input logic             ctl_idle
);

    AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_op) && $stable(bus_idx)); // R3
    AST_BUS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack |=> !bus_req); // R4
    AST_MISS_GOES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_valid && lcl_ready && !lcl_write && (lcl_state == 2'b00)
        |=> bus_req && (bus_op == 2'b01)); // R4
    AST_DIRTY_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_valid && lcl_ready && lcl_write && (lcl_state == 2'b11) |=> !bus_req); // R2
    AST_FROZEN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wthru_off && ctl_idle |-> !wb_valid); // R6
    AST_INV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_idle && cmd_inv_all && !snp_valid |-> !wb_valid); // R9
    AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_idle && cmd_inv_all |=> (lcl_state == 2'b00)); // R9
    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_idle |-> !lcl_ready); // R12
    AST_SAME_LINE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && (snp_idx == lcl_idx) |-> !lcl_ready); // R12

endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.LINES(LINES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wthru_off (cfg_wthru_off),
    .lcl_valid     (lcl_valid),
    .lcl_write     (lcl_write),
    .lcl_idx       (lcl_idx),
    .lcl_ready     (lcl_ready),
    .lcl_state     (lcl_state),
    .snp_valid     (snp_valid),
    .snp_idx       (snp_idx),
    .bus_req       (bus_req),
    .bus_op        (bus_op),
    .bus_idx       (bus_idx),
    .bus_ack       (bus_ack),
    .cmd_inv_all   (cmd_inv_all),
    .wb_valid      (wb_valid),
    .ctl_idle      (ctl_idle)
);

// File: tb/coh_line_ctrl_bench.sv
// Bench: a vector table walked cycle by cycle, then directed tests for
// reset, the flush walk, snoop priority on the writeback port and command cases.
module coh_line_ctrl_bench;

    localparam int LINES = 8;
    localparam int IW    = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_fill_off, cfg_wthru_off;
    logic          lcl_valid, lcl_write;
    logic [IW-1:0] lcl_idx;
    logic          lcl_ready;
    logic [1:0]    lcl_state;
    logic          snp_valid, snp_write;
    logic [IW-1:0] snp_idx;
    logic          bus_shared, bus_req, bus_ack;
    logic [1:0]    bus_op;
    logic [IW-1:0] bus_idx;
    logic          cmd_inv_all, cmd_flush_all;
    logic          wb_valid;
    logic [IW-1:0] wb_idx;
    logic          ctl_idle;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    coh_line_ctrl #(.LINES(LINES)) u_coh_line_ctrl (
        .clk (clk), .rst_n (rst_n),
        .cfg_fill_off (cfg_fill_off), .cfg_wthru_off (cfg_wthru_off),
        .lcl_valid (lcl_valid), .lcl_write (lcl_write), .lcl_idx (lcl_idx),
        .lcl_ready (lcl_ready), .lcl_state (lcl_state),
        .snp_valid (snp_valid), .snp_write (snp_write), .snp_idx (snp_idx),
        .bus_shared (bus_shared), .bus_req (bus_req), .bus_op (bus_op),
        .bus_idx (bus_idx), .bus_ack (bus_ack),
        .cmd_inv_all (cmd_inv_all), .cmd_flush_all (cmd_flush_all),
        .wb_valid (wb_valid), .wb_idx (wb_idx), .ctl_idle (ctl_idle)
    );

    typedef struct packed {
        logic lv; logic lw; logic [2:0] li;
        logic sv; logic sw; logic [2:0] si;
        logic sh; logic ak; logic nf; logic nt; logic ci; logic cw;
        logic [1:0] est; logic erdy; logic ebreq; logic [1:0] ebop;
        logic ewb; logic [2:0] ewbi; logic [3:0] req;
    } vec_t;

    localparam int NV = 26;
    // Fields: lv lw li, sv sw si, sh ak, nf nt ci cw, est erdy ebreq ebop, ewb ewbi, req
    localparam vec_t VEC [NV] = '{
        '{1,0,1, 0,0,0, 0,0, 0,0,0,0, 0,1,0,0, 0,0, 4}, // R4 read miss line 1
        '{0,0,1, 0,0,0, 0,1, 0,0,0,0, 0,0,1,1, 0,0, 4}, // R4 ack, not shared
        '{1,1,1, 0,0,0, 0,0, 0,0,0,0, 2,1,0,0, 0,0, 2}, // R2 write Exclusive
        '{1,1,1, 0,0,0, 0,0, 0,0,0,0, 3,1,0,0, 0,0, 2}, // R2 write Modified
        '{0,0,1, 1,0,1, 0,0, 0,0,0,0, 3,0,0,0, 1,1, 8}, // R8 snoop read of dirty
        '{0,0,1, 0,0,0, 0,0, 0,0,0,0, 1,1,0,0, 0,0, 8}, // R8 now Shared
        '{1,0,2, 0,0,0, 0,0, 0,0,0,0, 0,1,0,0, 0,0, 4}, // R4 read miss line 2
        '{0,0,2, 0,0,0, 1,1, 0,0,0,0, 0,0,1,1, 0,0, 4}, // R4 ack, shared
        '{1,1,2, 0,0,0, 0,0, 0,0,0,0, 1,1,0,0, 0,0, 3}, // R3 write Shared
        '{0,0,2, 0,0,0, 0,0, 0,0,0,0, 1,0,1,2, 0,0, 3}, // R3 waiting
        '{0,0,2, 0,0,0, 0,1, 0,0,0,0, 1,0,1,2, 0,0, 3}, // R3 ack
        '{0,0,2, 0,0,0, 0,0, 0,0,0,0, 2,1,0,0, 0,0, 3}, // R3 now Exclusive
        '{0,0,2, 1,0,2, 0,0, 0,0,0,0, 2,0,0,0, 0,0, 8}, // R8 snoop read Exclusive
        '{0,0,2, 1,1,2, 0,0, 0,0,0,0, 1,0,0,0, 0,0, 7}, // R7 snoop write
        '{0,0,2, 0,0,0, 0,0, 0,0,0,0, 0,1,0,0, 0,0, 7}, // R7 now Invalid
        '{1,1,3, 0,0,0, 0,0, 0,0,0,0, 0,1,0,0, 0,0, 3}, // R3 write Invalid
        '{0,0,3, 0,0,0, 0,1, 0,0,0,0, 0,0,1,2, 0,0, 3}, // R3 ack
        '{0,0,3, 0,0,0, 0,0, 0,0,0,0, 0,1,0,0, 0,0, 3}, // R3 stays Invalid
        '{1,0,4, 0,0,0, 0,0, 1,0,0,0, 0,1,0,0, 0,0, 5}, // R5 miss, fills off
        '{0,0,4, 0,0,0, 0,1, 1,0,0,0, 0,0,1,1, 0,0, 5}, // R5 ack
        '{0,0,4, 0,0,0, 0,0, 1,0,0,0, 0,1,0,0, 0,0, 5}, // R5 not filled
        '{1,1,1, 0,0,0, 0,0, 1,1,0,0, 1,1,0,0, 0,0, 6}, // R6 write Shared, frozen
        '{0,0,1, 1,1,1, 0,0, 1,1,0,0, 1,0,0,0, 0,0, 6}, // R6 snoop write ignored
        '{0,0,1, 0,0,0, 0,0, 1,1,0,0, 1,1,0,0, 0,0, 6}, // R6 still Shared
        '{0,0,1, 0,0,0, 0,0, 0,0,1,0, 1,0,0,0, 0,0, 9}, // R9 discard all
        '{0,0,1, 0,0,0, 0,0, 0,0,0,0, 0,1,0,0, 0,0, 9}  // R9 Invalid
    };

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_in();
        cfg_fill_off = 0; cfg_wthru_off = 0;
        lcl_valid = 0; lcl_write = 0; lcl_idx = '0;
        snp_valid = 0; snp_write = 0; snp_idx = '0;
        bus_shared = 0; bus_ack = 0; cmd_inv_all = 0; cmd_flush_all = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Read miss then acknowledge, leaving the line Exclusive or Shared.
    task automatic fill_line(input logic [IW-1:0] idx, input logic sh);
        @(negedge clk); clear_in(); lcl_valid = 1; lcl_idx = idx;
        @(negedge clk); clear_in(); lcl_idx = idx; bus_ack = 1; bus_shared = sh;
    endtask

    task automatic write_line(input logic [IW-1:0] idx);
        @(negedge clk); clear_in(); lcl_valid = 1; lcl_write = 1; lcl_idx = idx;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        summary();
        $finish;
    end

    initial begin
        clear_in();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state on several lines
        for (int i = 0; i < LINES; i += 3) begin
            lcl_idx = IW'(i);
            #1;
            chk("R1", "lcl_state", lcl_state, 0);
        end
        chk("R1", "lcl_ready", lcl_ready, 1);
        chk("R1", "bus_req", bus_req, 0);
        chk("R1", "wb_valid", wb_valid, 0);

        // Table walk: inputs at the falling edge, outputs checked before the rising edge
        for (int k = 0; k < NV; k++) begin
            string tg;
            @(negedge clk);
            lcl_valid = VEC[k].lv; lcl_write = VEC[k].lw; lcl_idx = VEC[k].li;
            snp_valid = VEC[k].sv; snp_write = VEC[k].sw; snp_idx = VEC[k].si;
            bus_shared = VEC[k].sh; bus_ack = VEC[k].ak;
            cfg_fill_off = VEC[k].nf; cfg_wthru_off = VEC[k].nt;
            cmd_inv_all = VEC[k].ci; cmd_flush_all = VEC[k].cw;
            #1;
            tg = $sformatf("R%0d vec%0d", VEC[k].req, k);
            chk(tg, "lcl_state", lcl_state, VEC[k].est);
            chk(tg, "lcl_ready", lcl_ready, VEC[k].erdy);
            chk(tg, "bus_req", bus_req, VEC[k].ebreq);
            chk(tg, "bus_op", bus_op, VEC[k].ebop);
            chk(tg, "wb_valid", wb_valid, VEC[k].ewb);
            if (VEC[k].ewb) chk(tg, "wb_idx", wb_idx, VEC[k].ewbi);
        end

        // R12: snoop write invalidates a Shared line while its write-through waits
        fill_line(3'd4, 1'b1);
        write_line(3'd4);
        @(negedge clk); clear_in(); lcl_idx = 3'd4; snp_valid = 1; snp_write = 1; snp_idx = 3'd4;
        #1;
        chk("R12", "bus_idx", bus_idx, 4);
        chk("R12", "bus_op", bus_op, 2);
        chk("R12", "lcl_state", lcl_state, 1);
        @(negedge clk); clear_in(); lcl_idx = 3'd4; bus_ack = 1;
        #1;
        chk("R12", "lcl_state", lcl_state, 0);
        @(negedge clk); clear_in(); lcl_idx = 3'd4;
        #1;
        chk("R12", "lcl_state after ack", lcl_state, 0);
        chk("R12", "lcl_ready", lcl_ready, 1);

        // R9: discard a dirty line without writeback
        fill_line(3'd7, 1'b0);
        write_line(3'd7);
        @(negedge clk); clear_in(); lcl_idx = 3'd7; cmd_inv_all = 1;
        #1;
        chk("R9", "lcl_state before", lcl_state, 3);
        chk("R9", "wb_valid", wb_valid, 0);
        @(negedge clk); clear_in(); lcl_idx = 3'd7;
        #1;
        chk("R9", "lcl_state after", lcl_state, 0);

        // R10 / R11: walk with dirty lines 0, 5, 6 and clean line 3
        fill_line(3'd0, 1'b0); write_line(3'd0);
        fill_line(3'd5, 1'b0); write_line(3'd5);
        fill_line(3'd6, 1'b0); write_line(3'd6);
        fill_line(3'd3, 1'b0);
        @(negedge clk); clear_in(); cmd_flush_all = 1;
        #1;
        chk("R10", "wb_valid at command", wb_valid, 0);
        @(negedge clk); clear_in();
        #1;
        chk("R10", "line0 wb_valid", wb_valid, 1);
        chk("R10", "line0 wb_idx", wb_idx, 0);
        chk("R10", "ctl_idle in walk", ctl_idle, 0);
        for (int p = 1; p <= 4; p++) begin
            @(negedge clk); clear_in();
            #1;
            chk("R10", $sformatf("line%0d wb_valid", p), wb_valid, 0);
        end
        @(negedge clk); clear_in(); snp_valid = 1; snp_idx = 3'd6;
        #1;
        chk("R11", "snoop wb_valid", wb_valid, 1);
        chk("R11", "snoop wb_idx", wb_idx, 6);
        @(negedge clk); clear_in();
        #1;
        chk("R11", "held line5 wb_valid", wb_valid, 1);
        chk("R11", "held line5 wb_idx", wb_idx, 5);
        @(negedge clk); clear_in();
        #1;
        chk("R10", "line6 wb_valid", wb_valid, 0);
        @(negedge clk); clear_in();
        #1;
        chk("R10", "line7 wb_valid", wb_valid, 0);
        chk("R10", "lcl_ready in walk", lcl_ready, 0);
        @(negedge clk); clear_in(); lcl_idx = 3'd6;
        #1;
        chk("R10", "ctl_idle after", ctl_idle, 1);
        chk("R10", "line6 state", lcl_state, 0);
        lcl_idx = 3'd0; #1; chk("R10", "line0 state", lcl_state, 0);
        lcl_idx = 3'd3; #1; chk("R10", "line3 state", lcl_state, 0);
        lcl_idx = 3'd5; #1; chk("R10", "line5 state", lcl_state, 0);

        summary();
        $finish;
    end

endmodule